// File: doc/BRIEF.md
# Hundredths/Tenths BCD Stopwatch with Overflow Interrupts

This peripheral keeps the sub-second part of a stopwatch. Two decimal digits, hundredths and tenths of a second, are held as 4-bit BCD values and advance from a 256 Hz timebase enable pulse. A fractional accumulator turns the timebase into exactly 100 hundredths ticks per 256 pulses. A run bit starts and freezes the count, so software can stop it, read a consistent pair of digits, and restart it. One tick that falls due while the count is frozen is kept and applied after the restart.

Each digit wrap from 9 to 0 is an event source. Source 0 is the hundredths wrap (10 Hz) and source 1 is the tenths wrap (1 Hz). Each source sets a factor flag whether or not it is masked. Software reads the flags, and that read clears them. The interrupt request is raised when any flag is set and its enable bit is also set. Software reaches the block through a simple register bus with a combinational read path.

Top module: `bcd_stopwatch`

## Requirements
- R1: After reset, both digits, both flags, both enable bits and the run bit read 0. The irq output is 0.
- R2: While running, the total number of hundredths ticks after P timebase pulses since reset is floor(100*P/256). Two ticks are never produced on consecutive clock cycles.
- R3: The hundredths digit is read at address 0 and the tenths digit at address 1, each on rdata[3:0] in BCD. Each digit counts 0 to 9 and wraps to 0. The tenths digit advances on the same clock edge as the hundredths wrap.
- R4: A bus write to address 0 or 1 leaves both digits unchanged.
- R5: The run bit is wdata[0] at address 4 and reads back on rdata[0]. While it is 0, the digits hold their value.
- R6: If one tick falls due while run is 0, the digits advance by exactly one, one clock edge after run becomes 1.
- R7: The flags are read at address 2. Bit 0 is set when the hundredths digit wraps and bit 1 when the tenths digit wraps. Each flag is set whatever its enable bit holds.
- R8: A bus write to address 2 leaves the flags unchanged.
- R9: A read strobe (rd_en) at address 2 clears the flags that were read. A flag being set in the same cycle as the read stays set.
- R10: The enable bits are at address 3, bits [1:0], and read back. irq is 1 exactly when some flag and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_en | input | 1 | One-cycle pulse at the 256 Hz timebase rate |
| addr | input | ADDR_W (3) | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; a read at address 2 clears the flags |
| wdata | input | NUM_DIG (2) | Write data |
| rdata | output | DIG_W (4) | Combinational read data |
| irq | output | 1 | Interrupt request: a flag that is also enabled |

## Verification
The bench builds the block with its defaults: a 256 Hz timebase, 100 ticks per second, and two digits. With these values, 256 pulses complete a full tenths cycle. That brings the 1 Hz flag and the tenths wrap within a few thousand clock cycles. The pulse counts in the stimulus table are uneven, so both 2-pulse and 3-pulse tick spacings occur, along with digit wraps at varied phases. Directed tests cover these cases: a tick held while paused, writes to read-only registers, and a flag set in the same cycle as its clearing read.

// File: rtl/sw_pkg.sv
package sw_pkg;
    localparam int DIG_W    = 4;
    localparam int DIG_LAST = 9;
    // offsets of control registers after the digit registers
    localparam int OFS_FLAG = 0;
    localparam int OFS_MASK = 1;
    localparam int OFS_RUN  = 2;
endpackage

// File: rtl/sw_tickgen.sv
module sw_tickgen #(
    parameter int TB_HZ   = 256,
    parameter int TICK_HZ = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tb_en_i,
    output logic tick_o
);
    localparam int ACC_W = $clog2(TB_HZ) + 1;
    localparam int SUM_W = ACC_W + 1;

    logic [ACC_W-1:0] acc_d, acc_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        acc_d  = acc_q;
        tick_o = 1'b0;
        sum    = {1'b0, acc_q} + SUM_W'(TICK_HZ);
        if (tb_en_i) begin
            if (sum >= SUM_W'(TB_HZ)) begin
                tick_o = 1'b1;
                acc_d  = ACC_W'(sum - SUM_W'(TB_HZ));
            end else begin
                acc_d  = ACC_W'(sum);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R2: a tick needs at least two pulses, so ticks never sit back to back
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/sw_digit.sv
module sw_digit
    import sw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [DIG_W-1:0] val_o,
    output logic             wrap_o
);
    logic [DIG_W-1:0] val_d, val_q;

    always_comb begin
        val_d  = val_q;
        wrap_o = inc_i && (val_q == DIG_W'(DIG_LAST));
        if (inc_i) val_d = wrap_o ? '0 : val_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val_o = val_q;

    assert_bcd_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        val_q <= DIG_W'(DIG_LAST));
    assert_hold_no_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(val_q));
endmodule

// File: rtl/bcd_stopwatch.sv
module bcd_stopwatch
    import sw_pkg::*;
#(
    parameter int TB_HZ   = 256,
    parameter int TICK_HZ = 100,
    parameter int NUM_DIG = 2,
    parameter int ADDR_W  = $clog2(NUM_DIG + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tb_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [NUM_DIG-1:0] wdata,
    output logic [DIG_W-1:0]  rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(NUM_DIG + OFS_FLAG);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(NUM_DIG + OFS_MASK);
    localparam logic [ADDR_W-1:0] A_RUN  = ADDR_W'(NUM_DIG + OFS_RUN);

    typedef struct packed {
        logic               run;
        logic               pend;
        logic [NUM_DIG-1:0] mask;
        logic [NUM_DIG-1:0] flag;
    } regs_t;

    regs_t st_d, st_q;

    logic               tick;
    logic               adv;
    logic [NUM_DIG:0]   inc;
    logic [NUM_DIG-1:0] wrap;
    logic [DIG_W-1:0]   dig_val [NUM_DIG];

    sw_tickgen #(.TB_HZ(TB_HZ), .TICK_HZ(TICK_HZ)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .tb_en_i (tb_en),
        .tick_o  (tick)
    );

    assign adv    = st_q.run && (st_q.pend || tick);
    assign inc[0] = adv;

    for (genvar k = 0; k < NUM_DIG; k++) begin : g_dig
        sw_digit u_dig (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc_i  (inc[k]),
            .val_o  (dig_val[k]),
            .wrap_o (wrap[k])
        );
        assign inc[k+1] = wrap[k];

        // R7: a wrap always leaves its flag set on the next cycle
        assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
            wrap[k] |=> st_q.flag[k]);
    end

    always_comb begin
        st_d = st_q;
        if (st_q.run) st_d.pend = st_q.pend && tick;
        else          st_d.pend = st_q.pend || tick;
        if (wr_en && addr == A_MASK) st_d.mask = wdata;
        if (wr_en && addr == A_RUN)  st_d.run  = wdata[0];
        if (rd_en && addr == A_FLAG) st_d.flag = '0;
        st_d.flag = st_d.flag | wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_DIG; k++)
            if (addr == ADDR_W'(k)) rdata = dig_val[k];
        if (addr == A_FLAG) rdata = DIG_W'(st_q.flag);
        if (addr == A_MASK) rdata = DIG_W'(st_q.mask);
        if (addr == A_RUN)  rdata = DIG_W'(st_q.run);
    end

    assign irq = |(st_q.flag & st_q.mask);

    // R6: a tick arriving while stopped is remembered
    assert_pend_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && tick) |=> st_q.pend);
    // R5: while stopped the low digit cannot move
    assert_stopped_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |=> $stable(dig_val[0]));
endmodule

// File: tb/bcd_stopwatch_tb.sv
`timescale 1ns/1ps
module bcd_stopwatch_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tb_en = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] wdata = '0;
    logic [3:0] rdata;
    logic       irq;

    int n_checks = 0;
    int n_errors = 0;

    // bench model, built from the requirements
    int  pulses = 0;
    int  ticks  = 0;
    bit  running = 0;
    bit  pend_m  = 0;
    bit [1:0] ef = 2'b00;
    bit [1:0] mask_m = 2'b00;

    localparam int NSTEP = 10;
    localparam int STEP_N [NSTEP] = '{1, 2, 3, 4, 7, 13, 25, 60, 100, 41};

    bcd_stopwatch u_dut (
        .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    function automatic int tk(int p);
        return (100 * p) / 256;
    endfunction

    task automatic chk(int act, int exp, string req);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic adv_model();
        if (ticks % 10 == 9)   ef[0] = 1'b1;
        if (ticks % 100 == 99) ef[1] = 1'b1;
        ticks++;
    endtask

    task automatic pulse();
        bit t;
        t = tk(pulses + 1) > tk(pulses);
        pulses++;
        @(negedge clk) tb_en = 1'b1;
        @(negedge clk) tb_en = 1'b0;
        if (t) begin
            if (running) adv_model();
            else         pend_m = 1'b1;
        end
    endtask

    task automatic bus_write(int a, int d);
        @(negedge clk);
        addr = 3'(a); wdata = 2'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(int a, output int v);
        @(negedge clk);
        addr = 3'(a);
        #1 v = int'(rdata);
    endtask

    task automatic read_flags(output int v);
        @(negedge clk);
        addr = 3'd2; rd_en = 1'b1;
        #1 v = int'(rdata);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_digits(string req);
        int v;
        peek(0, v); chk(v, ticks % 10, req);
        peek(1, v); chk(v, (ticks / 10) % 10, req);
    endtask

    initial begin
        #(5.0 * 150000);
        n_errors++;
        $display("FAIL watchdog: got 0 expected 1 (run completed)");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            peek(a, v); chk(v, 0, "R1 register reset");
        end
        chk(int'(irq), 0, "R1 irq reset");

        // enable source 0 only, start counting; run readback (R5)
        bus_write(3, 1); mask_m = 2'b01;
        bus_write(4, 1); running = 1'b1;
        peek(4, v); chk(v, 1, "R5 run readback");

        // table of pulse bursts
        for (int s = 0; s < NSTEP; s++) begin
            for (int n = 0; n < STEP_N[s]; n++) pulse();
            chk(ticks, tk(pulses), "R2 tick formula");
            chk_digits("R2/R3 digits");
            chk(int'(irq), int'(|(ef & mask_m)), "R10 irq");
            read_flags(v);
            chk(v, int'(ef), "R7 flags");
            ef = 2'b00;
            peek(2, v); chk(v, 0, "R9 flags cleared by read");
        end

        // R4: writes to the digit registers are ignored
        bus_write(0, 3); bus_write(1, 2);
        chk_digits("R4 digits unchanged after write");

        // R8: write to flag register ignored
        bus_write(2, 3);
        peek(2, v); chk(v, 0, "R8 flags unchanged after write");
        chk(int'(irq), 0, "R8 irq stays low");

        // R10: enable readback
        bus_write(3, 3); mask_m = 2'b11;
        peek(3, v); chk(v, 3, "R10 mask readback");

        // R5/R6: stop, let one tick fall due, resume
        bus_write(4, 0); running = 1'b0;
        for (int n = 0; n < 3 && !pend_m; n++) pulse();
        chk(int'(pend_m), 1, "R6 bench produced a paused tick");
        chk_digits("R5 digits held while stopped");
        bus_write(4, 1); running = 1'b1;
        @(negedge clk);
        if (pend_m) begin adv_model(); pend_m = 1'b0; end
        chk_digits("R6 pending tick applied after resume");
        read_flags(v); ef = 2'b00;

        // R9: flag set in the same cycle as the clearing read
        while (!((ticks % 10 == 9) && (tk(pulses + 1) > tk(pulses)))) pulse();
        @(negedge clk);
        tb_en = 1'b1; rd_en = 1'b1; addr = 3'd2;
        #1 v = int'(rdata);
        chk(v, 0, "R9 flags before coincident set");
        @(negedge clk);
        tb_en = 1'b0; rd_en = 1'b0;
        pulses++;
        adv_model();
        peek(2, v); chk(v & 1, 1, "R9 set wins over read clear");
        chk(int'(irq), 1, "R10 irq from enabled flag");
        chk_digits("R3 wrap to zero");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule